// File: doc/BRIEF.md
# Twenty-State Sequencer with Registered Controls

This block is a sequencing controller that steps through twenty operating states held in a five-bit binary state register. From an idle state it waits for a start request and then walks forward one state per clock. Along the way it drives four control strobes in turn: a latch enable, a bus-drive (tristate) enable, a register load enable and a counter enable. A hold request freezes the walk and an abort request returns it to idle. None of the strobes is a combinational decode. Each one comes from its own flip-flop, which is reloaded on every rising edge, so the strobes cannot glitch while the state bits settle.

The three request inputs are asynchronous to the block. Each passes through a two-stage synchronizer before the next-state logic sees it. The active-low reset takes effect at once when asserted. Its release passes through a two-stage synchronizer, so every state bit leaves reset on the same edge. The twelve unused encodings (20 to 31) are treated as upsets. If the state register ever holds one of them, the next edge returns the machine to idle with every strobe inactive, and a fault flag is raised that stays set until reset.

Top module: `ctl_fsm`

## Requirements
- R1: While `rst_n_i` is low, `state_o` reads 0 and every strobe and `fault_o` read 0, starting from the moment reset falls and without waiting for a clock edge.
- R2: After `rst_n_i` rises between edges with `start_i` held high, `state_o` stays 0 through the fourth rising edge and reads 1 after the fifth.
- R3: A request applied at the input pins between edges reaches the state register on the third rising edge after it is applied, because it first passes two synchronizing flops.
- R4: In state 0 the machine stays put until it sees a start request, and then moves to state 1. Hold and abort have no effect in state 0.
- R5: In states 1 to 18, with neither hold nor abort seen, the state rises by one on each edge. State 19 goes to state 0 on the next edge.
- R6: In states 1 to 19, a hold request seen without abort keeps the state unchanged.
- R7: An abort request seen in states 1 to 19 sends the machine to state 0 on the next edge, even if hold is also seen.
- R8: The strobe each state selects is: `latch_en_o` for states 1 to 4, `drive_en_o` for 5 to 12, `load_en_o` for 13 to 16 and `count_en_o` for 17 to 19. No strobe is selected in state 0 or in an unused encoding. At most one strobe is high at a time.
- R9: The strobes show the selection for the state the register held one clock earlier. They change only at rising edges, whatever the inputs do between edges.
- R10: If the state register holds any encoding from 20 to 31, the next edge loads state 0, and the strobes loaded on that edge are all inactive.
- R11: `fault_o` goes high on the edge that leaves an unused encoding. It stays high until reset, and reset clears it.
- R12: `state_o` always shows the contents of the state register, including an unused encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine clock, rising edge active |
| rst_n_i | input | 1 | Active-low reset: asserts asynchronously, releases synchronously inside the block |
| start_i | input | 1 | Asynchronous request to leave idle |
| hold_i | input | 1 | Asynchronous request to freeze the sequence |
| abort_i | input | 1 | Asynchronous request to return to idle |
| latch_en_o | output | 1 | Registered latch enable strobe |
| drive_en_o | output | 1 | Registered bus-drive (tristate) enable strobe |
| load_en_o | output | 1 | Registered register-load enable strobe |
| count_en_o | output | 1 | Registered counter enable strobe |
| fault_o | output | 1 | Sticky flag: an unused state encoding was seen |
| state_o | output | 5 | Current state register contents |

## Verification
The clocked properties observe the synchronized copies of the requests. They rely on the pins changing only between edges, and the stimulus therefore drives every input at the falling edge or shortly after it. The properties also assume that the only way an unused encoding can appear is an upset that lands between two edges. The stimulus creates such upsets by forcing the state register for part of a cycle. For that reason the step and hold properties accept an unused encoding in place of the expected successor, while the recovery properties check what follows. Reset is asserted and released away from rising edges, so the cycle count from release to the first state change is well defined.

// File: rtl/ctl_fsm_pkg.sv
package ctl_fsm_pkg;

  // Strobe bundle, one bit per control output.
  typedef struct packed {
    logic latch_en;
    logic drive_en;
    logic load_en;
    logic count_en;
  } ctl_word_t;

  // Inclusive state ranges that select each strobe.
  localparam int unsigned LATCH_FIRST = 1;
  localparam int unsigned LATCH_LAST  = 4;
  localparam int unsigned DRIVE_FIRST = 5;
  localparam int unsigned DRIVE_LAST  = 12;
  localparam int unsigned LOAD_FIRST  = 13;
  localparam int unsigned LOAD_LAST   = 16;
  localparam int unsigned COUNT_FIRST = 17;

  // Strobe selection for one state value; unused encodings select nothing.
  function automatic ctl_word_t select_word(input int unsigned st, input int unsigned n_states);
    ctl_word_t w;
    w = '0;
    if (st < n_states) begin
      w.latch_en = (st >= LATCH_FIRST) && (st <= LATCH_LAST);
      w.drive_en = (st >= DRIVE_FIRST) && (st <= DRIVE_LAST);
      w.load_en  = (st >= LOAD_FIRST)  && (st <= LOAD_LAST);
      w.count_en = (st >= COUNT_FIRST);
    end
    return w;
  endfunction

endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [DEPTH-1:0] chain_q;

  // Assertion clears the chain at once; release ripples a one through it.
  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[DEPTH-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[DEPTH-1];

endmodule

// File: rtl/ctl_sync_bus.sv
module ctl_sync_bus #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  // Independent flop chain per bit; stage 0 is the capture flop.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        stage_q[i] <= '0;
      end
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < int'(DEPTH); i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_o = stage_q[DEPTH-1];

endmodule

// File: rtl/ctl_fsm_core.sv
module ctl_fsm_core #(
  parameter int unsigned ST_W   = 5,
  parameter int unsigned NUM_ST = 20
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            start_i,
  input  logic            hold_i,
  input  logic            abort_i,
  output logic [ST_W-1:0] state_o,
  output logic            illegal_o
);

  localparam int unsigned LAST_ST = NUM_ST - 1;

  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  int unsigned     cur_st;
  int unsigned     nxt_st;

  // Next-state decision.
  always_comb begin
    cur_st = 32'(state_q);
    nxt_st = cur_st;
    if (cur_st >= NUM_ST) begin
      nxt_st = 0;
    end else if (cur_st == 0) begin
      nxt_st = start_i ? 1 : 0;
    end else if (abort_i) begin
      nxt_st = 0;
    end else if (hold_i) begin
      nxt_st = cur_st;
    end else if (cur_st == LAST_ST) begin
      nxt_st = 0;
    end else begin
      nxt_st = cur_st + 1;
    end
    state_d = ST_W'(nxt_st);
  end

  // State register.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign illegal_o = (32'(state_q) >= NUM_ST);

endmodule

// File: rtl/ctl_out_reg.sv
module ctl_out_reg
  import ctl_fsm_pkg::*;
#(
  parameter int unsigned ST_W   = 5,
  parameter int unsigned NUM_ST = 20
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic [ST_W-1:0] state_i,
  input  logic            illegal_i,
  output ctl_word_t       word_o,
  output logic            fault_o
);

  ctl_word_t word_d;
  logic      fault_d;

  always_comb begin
    word_d  = illegal_i ? '0 : select_word(32'(state_i), NUM_ST);
    fault_d = fault_o | illegal_i;
  end

  // Output register, reloaded on every edge.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      word_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      word_o  <= word_d;
      fault_o <= fault_d;
    end
  end

endmodule

// File: rtl/ctl_fsm.sv
module ctl_fsm
  import ctl_fsm_pkg::*;
#(
  parameter int unsigned ST_W       = 5,
  parameter int unsigned NUM_ST     = 20,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned RST_DEPTH  = 2
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            start_i,
  input  logic            hold_i,
  input  logic            abort_i,
  output logic            latch_en_o,
  output logic            drive_en_o,
  output logic            load_en_o,
  output logic            count_en_o,
  output logic            fault_o,
  output logic [ST_W-1:0] state_o
);

  localparam int unsigned REQ_W = 3;

  logic             rst_n_sync;
  logic [REQ_W-1:0] req_sync;
  logic             start_s;
  logic             hold_s;
  logic             abort_s;
  logic             illegal;
  ctl_word_t        word;

  ctl_rst_sync #(
    .DEPTH (RST_DEPTH)
  ) u_rst (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .rst_n_o  (rst_n_sync)
  );

  ctl_sync_bus #(
    .WIDTH (REQ_W),
    .DEPTH (SYNC_DEPTH)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_sync),
    .async_i ({abort_i, hold_i, start_i}),
    .sync_o  (req_sync)
  );

  assign start_s = req_sync[0];
  assign hold_s  = req_sync[1];
  assign abort_s = req_sync[2];

  ctl_fsm_core #(
    .ST_W   (ST_W),
    .NUM_ST (NUM_ST)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_sync),
    .start_i   (start_s),
    .hold_i    (hold_s),
    .abort_i   (abort_s),
    .state_o   (state_o),
    .illegal_o (illegal)
  );

  ctl_out_reg #(
    .ST_W   (ST_W),
    .NUM_ST (NUM_ST)
  ) u_out (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_sync),
    .state_i   (state_o),
    .illegal_i (illegal),
    .word_o    (word),
    .fault_o   (fault_o)
  );

  assign latch_en_o = word.latch_en;
  assign drive_en_o = word.drive_en;
  assign load_en_o  = word.load_en;
  assign count_en_o = word.count_en;

endmodule

// File: rtl/ctl_fsm_chk.sv
module ctl_fsm_chk #(
  parameter int unsigned ST_W   = 5,
  parameter int unsigned NUM_ST = 20
) (
  input logic            clk_i,
  input logic            rst_n_i,
  input logic            rst_n_int,
  input logic            start_s,
  input logic            hold_s,
  input logic            abort_s,
  input logic [ST_W-1:0] state_o,
  input logic            latch_en_o,
  input logic            drive_en_o,
  input logic            load_en_o,
  input logic            count_en_o,
  input logic            fault_o
);

  logic [3:0] strobes;
  logic       in_unused;
  logic       running;
  logic       at_last;

  assign strobes   = {latch_en_o, drive_en_o, load_en_o, count_en_o};
  assign in_unused = (32'(state_o) >= NUM_ST);
  assign running   = (state_o != '0) && !in_unused;
  assign at_last   = (32'(state_o) == NUM_ST - 1);

  always @(posedge clk_i) begin
    if (!rst_n_i) begin
      AST_RESET_CLEAR: assert ((state_o == '0) && (strobes == '0) && !fault_o)
        else $error("reset did not clear state and strobes"); // R1
    end
  end

  AST_IDLE_START: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (state_o == '0) && start_s |=> (32'(state_o) == 1))
    else $error("start not taken from idle"); // R4

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    running && !at_last && !hold_s && !abort_s |=> (32'(state_o) == 32'($past(state_o)) + 1) || in_unused)
    else $error("sequence did not advance by one"); // R5

  AST_WRAP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    at_last && !hold_s && !abort_s |=> (state_o == '0))
    else $error("last state did not return to idle"); // R5

  AST_HOLD_STILL: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    running && hold_s && !abort_s |=> $stable(state_o) || in_unused)
    else $error("hold did not freeze the state"); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    running && abort_s |=> (state_o == '0))
    else $error("abort did not return to idle"); // R7

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $onehot0(strobes))
    else $error("more than one strobe active"); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ($past(state_o) == '0) |-> (strobes == '0))
    else $error("strobe active one clock after idle"); // R9

  AST_UNUSED_EXIT: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    in_unused |=> (state_o == '0) && (strobes == '0))
    else $error("unused encoding not left"); // R10

  AST_FAULT_SET: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    in_unused |=> fault_o)
    else $error("fault flag not raised"); // R11

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    fault_o |=> fault_o)
    else $error("fault flag dropped without reset"); // R11

endmodule

bind ctl_fsm ctl_fsm_chk #(
  .ST_W   (ST_W),
  .NUM_ST (NUM_ST)
) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .rst_n_int  (rst_n_sync),
  .start_s    (start_s),
  .hold_s     (hold_s),
  .abort_s    (abort_s),
  .state_o    (state_o),
  .latch_en_o (latch_en_o),
  .drive_en_o (drive_en_o),
  .load_en_o  (load_en_o),
  .count_en_o (count_en_o),
  .fault_o    (fault_o)
);

// File: tb/ctl_fsm_tb.sv
module ctl_fsm_tb;

  logic       clk;
  logic       rst_n_i;
  logic       start_i;
  logic       hold_i;
  logic       abort_i;
  logic       latch_en_o;
  logic       drive_en_o;
  logic       load_en_o;
  logic       count_en_o;
  logic       fault_o;
  logic [4:0] state_o;
  logic [3:0] strobes;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  assign strobes = {latch_en_o, drive_en_o, load_en_o, count_en_o};

  ctl_fsm u_dut (
    .clk_i      (clk),
    .rst_n_i    (rst_n_i),
    .start_i    (start_i),
    .hold_i     (hold_i),
    .abort_i    (abort_i),
    .latch_en_o (latch_en_o),
    .drive_en_o (drive_en_o),
    .load_en_o  (load_en_o),
    .count_en_o (count_en_o),
    .fault_o    (fault_o),
    .state_o    (state_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected strobe pattern {latch, drive, load, count} for a state (R8).
  function automatic logic [3:0] want_strobes(input int s);
    if (s >= 1 && s <= 4)   return 4'b1000;
    if (s >= 5 && s <= 12)  return 4'b0100;
    if (s >= 13 && s <= 16) return 4'b0010;
    if (s >= 17 && s <= 19) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance n rising edges, then stop at the following falling edge.
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n_i = 1'b0;
    start_i = 1'b0;
    hold_i  = 1'b0;
    abort_i = 1'b0;
    tick(2);
    rst_n_i = 1'b1;
    tick(2);
  endtask

  // From idle with quiet inputs, reach state n (n >= 1).
  task automatic go_to(input int n);
    start_i = 1'b1;
    tick(3);
    start_i = 1'b0;
    if (n > 1) tick(n - 1);
  endtask

  task automatic t_reset_values();
    do_reset();
    check("R1 state after reset", 32'(state_o), 0);
    check("R1 strobes after reset", 32'(strobes), 0);
    check("R1 fault after reset", 32'(fault_o), 0);
  endtask

  task automatic t_idle_wait();
    hold_i  = 1'b1;
    abort_i = 1'b1;
    tick(5);
    check("R4 idle ignores hold/abort", 32'(state_o), 0);
    check("R4 idle strobes", 32'(strobes), 0);
    hold_i  = 1'b0;
    abort_i = 1'b0;
    tick(3);
  endtask

  task automatic t_full_walk();
    start_i = 1'b1;
    tick(2);
    check("R3 start not yet through synchronizer", 32'(state_o), 0);
    tick(1);
    check("R4 start moves to state 1", 32'(state_o), 1);
    check("R9 strobes lag idle", 32'(strobes), 0);
    start_i = 1'b0;
    for (int k = 1; k <= 19; k++) begin
      check("R5 walk state", 32'(state_o), 32'(k));
      check("R8 R9 walk strobes", 32'(strobes), 32'(want_strobes(k - 1)));
      tick(1);
    end
    check("R5 wrap to idle", 32'(state_o), 0);
    check("R9 strobes of state 19", 32'(strobes), 32'(want_strobes(19)));
    tick(1);
    check("R9 strobes quiet after idle", 32'(strobes), 0);
  endtask

  task automatic t_hold_abort();
    go_to(6);
    hold_i = 1'b1;
    tick(2);
    check("R3 hold reaches core on third edge", 32'(state_o), 8);
    tick(4);
    check("R6 hold keeps state", 32'(state_o), 8);
    check("R8 drive strobe while held", 32'(strobes), 32'(4'b0100));
    abort_i = 1'b1;
    tick(2);
    check("R3 abort not yet through", 32'(state_o), 8);
    tick(1);
    check("R7 abort beats hold", 32'(state_o), 0);
    hold_i  = 1'b0;
    abort_i = 1'b0;
    tick(3);
  endtask

  task automatic t_abort_mid();
    go_to(14);
    abort_i = 1'b1;
    tick(2);
    check("R3 abort latency", 32'(state_o), 16);
    tick(1);
    check("R7 abort to idle", 32'(state_o), 0);
    check("R9 load strobe one clock late", 32'(strobes), 32'(4'b0010));
    tick(1);
    check("R9 strobes quiet after abort", 32'(strobes), 0);
    abort_i = 1'b0;
    tick(3);
  endtask

  task automatic t_isolation_and_upset();
    go_to(6);
    hold_i = 1'b1;
    tick(3);
    check("R6 held at 8", 32'(state_o), 8);
    start_i = 1'b1; abort_i = 1'b1; hold_i = 1'b0;
    #1;
    check("R9 strobes ignore mid-cycle inputs", 32'(strobes), 32'(4'b0100));
    start_i = 1'b0; abort_i = 1'b0; hold_i = 1'b1;
    #1;
    check("R9 strobes stable after restore", 32'(strobes), 32'(4'b0100));
    tick(1);
    check("R6 still held", 32'(state_o), 8);
    force u_dut.u_fsm.state_q = 5'd25;
    #1;
    release u_dut.u_fsm.state_q;
    check("R12 state shows unused encoding", 32'(state_o), 25);
    tick(1);
    check("R10 leave encoding 25", 32'(state_o), 0);
    check("R10 strobes inactive after upset", 32'(strobes), 0);
    check("R11 fault raised", 32'(fault_o), 1);
    hold_i = 1'b0;
    tick(10);
    check("R11 fault sticky", 32'(fault_o), 1);
    check("R10 stays idle", 32'(state_o), 0);
  endtask

  task automatic t_upset_bounds();
    do_reset();
    check("R11 reset clears fault", 32'(fault_o), 0);
    force u_dut.u_fsm.state_q = 5'd20;
    #1;
    release u_dut.u_fsm.state_q;
    tick(1);
    check("R10 leave encoding 20", 32'(state_o), 0);
    check("R11 fault for 20", 32'(fault_o), 1);
    do_reset();
    force u_dut.u_fsm.state_q = 5'd31;
    #1;
    release u_dut.u_fsm.state_q;
    tick(1);
    check("R10 leave encoding 31", 32'(state_o), 0);
    check("R11 fault for 31", 32'(fault_o), 1);
    do_reset();
    force u_dut.u_fsm.state_q = 5'd19;
    #1;
    release u_dut.u_fsm.state_q;
    tick(1);
    check("R5 state 19 wraps", 32'(state_o), 0);
    check("R11 no fault for 19", 32'(fault_o), 0);
    check("R8 count strobe for 19", 32'(strobes), 32'(4'b0001));
    tick(1);
  endtask

  task automatic t_async_reset();
    force u_dut.u_fsm.state_q = 5'd27;
    #1;
    release u_dut.u_fsm.state_q;
    tick(3);
    go_to(6);
    hold_i = 1'b1;
    tick(3);
    check("R11 fault set before reset", 32'(fault_o), 1);
    check("R8 drive before reset", 32'(strobes), 32'(4'b0100));
    #2;
    rst_n_i = 1'b0;
    #1;
    check("R1 state cleared without edge", 32'(state_o), 0);
    check("R1 strobes cleared without edge", 32'(strobes), 0);
    check("R1 fault cleared without edge", 32'(fault_o), 0);
    hold_i  = 1'b0;
    start_i = 1'b1;
    tick(2);
    rst_n_i = 1'b1;
    tick(4);
    check("R2 still idle four edges after release", 32'(state_o), 0);
    tick(1);
    check("R2 moves on fifth edge", 32'(state_o), 1);
    start_i = 1'b0;
    tick(20);
  endtask

  initial begin
    rst_n_i = 1'b1;
    start_i = 1'b0;
    hold_i  = 1'b0;
    abort_i = 1'b0;
    #1;
    rst_n_i = 1'b0;
    @(negedge clk);
    t_reset_values();
    t_idle_wait();
    t_full_walk();
    t_hold_abort();
    t_abort_mid();
    t_isolation_and_upset();
    t_upset_bounds();
    t_async_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule